// File: doc/BRIEF.md
# Timer Compare Channels with Pulse Output

This block holds a set of compare channels attached to a free-running time counter. Each channel keeps a compare value and a small control word. Every cycle it compares the counter input with its active compare value. On a hit it latches a match flag, can raise an interrupt, and drives its output pin according to the selected mode: it either inverts the pin or emits a single-cycle high pulse. Software programs a repeating pulse, for example a once-per-second strobe, by queuing the next compare value while the current one is still waiting.

The compare value is double-buffered. A compare write made while the channel's mode is zero loads the active value directly and arms the channel. A compare write made while the channel is running is parked in a holding register and becomes the active value at the next hit. A control write takes one cycle to show in the readback. Software therefore writes mode zero, reads it back as zero, and only then writes the first compare value.

Top module: `tcmp_top`

## Requirements
- R1: After reset every control word, the status word, every pin and every interrupt line read zero.
- R2: A channel whose mode is nonzero and which is armed sets its flag on the first clock edge at which the counter input equals its active compare value. Mode codes other than 0x5 and 0xF still set the flag but keep the pin low.
- R3: A control write with bit 5 set to 1 clears that channel's flag. A write with bit 5 at 0 leaves the flag unchanged. A hit in the same cycle as the clear leaves the flag set.
- R4: A channel's interrupt line is high exactly while its interrupt enable (control bit 4) and its flag are both 1.
- R5: In mode 0x5 the pin inverts on the clock edge of each hit.
- R6: In mode 0xF the pin is high for exactly one cycle after each hit.
- R7: A compare write made while the mode is nonzero does not change the active value (which the compare address reads back). At the next hit the held value becomes active and the channel stays armed.
- R8: After a hit with no held value the channel disarms, and the counter meeting the same value again sets no flag.
- R9: A control write with mode 0 disables the channel, forces the pin low, disarms the channel and discards any held value. Re-enabling without a new compare write produces no hit.
- R10: A written mode field reads back in the following cycle. A compare write made while the mode reads zero becomes the active value and arms the channel.
- R11: The status word at address 0 mirrors the flags of channels 0 to NUM_CH-1 in bits 0 upward. Writes to address 0 change nothing.
- R12: Channel n has its control word at address 1+2n and its compare value at 2+2n. The control word is laid out as mode in bits 3:0, interrupt enable in bit 4 and flag in bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| timeVal | input | CNT_W | Current time counter value |
| regWr | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register word address |
| regWdata | input | CNT_W | Register write data |
| regRdata | output | CNT_W | Register read data for regAddr (combinational) |
| pinOut | output | NUM_CH | Per-channel output pins |
| irqOut | output | NUM_CH | Per-channel interrupt lines |

## Verification
The hardest state to reach from the ports is a channel that is armed with a held value waiting behind the active one. Reaching it takes a disable, a compare write, an enable, and a second compare write, in that order, before the counter reaches the first value. The stimulus follows that sequence on one channel with random compare values and random interrupt enables. It then walks the counter across both values, expecting the pin to invert twice. Directed cases cover disabling with a held value, the one-shot disarm, and the single-cycle pulse.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  localparam int MODE_W = 4;
  localparam logic [MODE_W-1:0] MODE_OFF    = 4'h0;
  localparam logic [MODE_W-1:0] MODE_TOGGLE = 4'h5;
  localparam logic [MODE_W-1:0] MODE_PULSE  = 4'hF;
  localparam int IE_BIT   = 4;
  localparam int FLAG_BIT = 5;
  localparam int CTRL_W   = 6;

  typedef struct packed {
    logic loadActive;
    logic loadPending;
    logic disarm;
  } cmpStrobe_t;
endpackage

// File: rtl/tcmp_dp.sv
module tcmp_dp
  import tcmp_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [CNT_W-1:0]                  timeVal,
  input  logic [CNT_W-1:0]                  wrData,
  input  cmpStrobe_t [NUM_CH-1:0]           strobeIn,
  input  logic [NUM_CH-1:0]                 chEnIn,
  output logic [NUM_CH-1:0]                 matchOut,
  output logic [NUM_CH-1:0][CNT_W-1:0]      activeOut
);
  logic [NUM_CH-1:0][CNT_W-1:0] activeQ;
  logic [NUM_CH-1:0][CNT_W-1:0] pendQ;
  logic [NUM_CH-1:0]            pendValidQ;
  logic [NUM_CH-1:0]            armedQ;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic hit;
    assign hit         = chEnIn[n] && armedQ[n] && (timeVal == activeQ[n]);
    assign matchOut[n] = hit;
    assign activeOut[n] = activeQ[n];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        activeQ[n]    <= '0;
        pendQ[n]      <= '0;
        pendValidQ[n] <= 1'b0;
        armedQ[n]     <= 1'b0;
      end else if (strobeIn[n].disarm) begin
        armedQ[n]     <= 1'b0;
        pendValidQ[n] <= 1'b0;
      end else if (strobeIn[n].loadActive) begin
        activeQ[n]    <= wrData;
        armedQ[n]     <= 1'b1;
        pendValidQ[n] <= 1'b0;
      end else begin
        if (hit) begin
          if (pendValidQ[n])                activeQ[n] <= pendQ[n];
          else if (strobeIn[n].loadPending) activeQ[n] <= wrData;
          else                              armedQ[n]  <= 1'b0;
        end
        if (strobeIn[n].loadPending && !(hit && !pendValidQ[n])) begin
          pendQ[n]      <= wrData;
          pendValidQ[n] <= 1'b1;
        end else if (hit) begin
          pendValidQ[n] <= 1'b0;
        end
      end
    end

    // R9
    disarm_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobeIn[n].disarm |=> !armedQ[n]);
    // R7
    reload_chk: assert property (@(posedge clk) disable iff (!rstN)
      (hit && pendValidQ[n] && !strobeIn[n].disarm) |=>
        (armedQ[n] && activeQ[n] == $past(pendQ[n])));
    // R8
    one_shot_chk: assert property (@(posedge clk) disable iff (!rstN)
      (hit && !pendValidQ[n] && !strobeIn[n].loadPending && !strobeIn[n].loadActive) |=> !armedQ[n]);
  end
endmodule

// File: rtl/tcmp_ctrl.sv
module tcmp_ctrl
  import tcmp_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWr,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [CTRL_W-1:0]             ctrlWdata,
  output logic [CNT_W-1:0]              regRdata,
  input  logic [NUM_CH-1:0]             matchIn,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  activeIn,
  output cmpStrobe_t [NUM_CH-1:0]       strobeOut,
  output logic [NUM_CH-1:0]             chEnOut,
  output logic [NUM_CH-1:0]             pinOut,
  output logic [NUM_CH-1:0]             irqOut
);
  logic [NUM_CH-1:0][MODE_W-1:0] modeQ;
  logic [NUM_CH-1:0]             ieQ;
  logic [NUM_CH-1:0]             flagQ;
  logic [NUM_CH-1:0]             pinQ;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(1 + 2 * n);
    localparam logic [ADDR_W-1:0] CMP_A  = ADDR_W'(2 + 2 * n);
    logic wrCtrl, wrCmp, modeOff;

    assign wrCtrl  = regWr && (regAddr == CTRL_A);
    assign wrCmp   = regWr && (regAddr == CMP_A);
    assign modeOff = (modeQ[n] == MODE_OFF);

    assign strobeOut[n].loadActive  = wrCmp && modeOff;
    assign strobeOut[n].loadPending = wrCmp && !modeOff;
    assign strobeOut[n].disarm      = wrCtrl && (ctrlWdata[MODE_W-1:0] == MODE_OFF);
    assign chEnOut[n] = !modeOff;
    assign irqOut[n]  = ieQ[n] && flagQ[n];
    assign pinOut[n]  = pinQ[n];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        modeQ[n] <= MODE_OFF;
        ieQ[n]   <= 1'b0;
        flagQ[n] <= 1'b0;
        pinQ[n]  <= 1'b0;
      end else begin
        if (wrCtrl) begin
          modeQ[n] <= ctrlWdata[MODE_W-1:0];
          ieQ[n]   <= ctrlWdata[IE_BIT];
        end
        if (matchIn[n])                          flagQ[n] <= 1'b1;
        else if (wrCtrl && ctrlWdata[FLAG_BIT])  flagQ[n] <= 1'b0;
        unique case (modeQ[n])
          MODE_TOGGLE: pinQ[n] <= pinQ[n] ^ matchIn[n];
          MODE_PULSE:  pinQ[n] <= matchIn[n];
          default:     pinQ[n] <= 1'b0;
        endcase
      end
    end

    // R2
    flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      matchIn[n] |=> flagQ[n]);
    // R3
    flag_src_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flagQ[n]) |-> $past(matchIn[n]));
    // R5
    toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
      (modeQ[n] == MODE_TOGGLE && matchIn[n]) |=> (pinQ[n] != $past(pinQ[n])));
    // R6
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
      (modeQ[n] == MODE_PULSE && pinQ[n] && !matchIn[n]) |=> !pinQ[n]);
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == '0) regRdata = CNT_W'(flagQ);
    for (int i = 0; i < NUM_CH; i++) begin
      if (regAddr == ADDR_W'(1 + 2 * i))
        regRdata = CNT_W'({flagQ[i], ieQ[i], modeQ[i]});
      if (regAddr == ADDR_W'(2 + 2 * i))
        regRdata = activeIn[i];
    end
  end
endmodule

// File: rtl/tcmp_top.sv
module tcmp_top
  import tcmp_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  timeVal,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWdata,
  output logic [CNT_W-1:0]  regRdata,
  output logic [NUM_CH-1:0] pinOut,
  output logic [NUM_CH-1:0] irqOut
);
  cmpStrobe_t [NUM_CH-1:0]      strobe;
  logic [NUM_CH-1:0]            chEn;
  logic [NUM_CH-1:0]            match;
  logic [NUM_CH-1:0][CNT_W-1:0] active;

  tcmp_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .ctrlWdata(regWdata[CTRL_W-1:0]), .regRdata(regRdata),
    .matchIn(match), .activeIn(active), .strobeOut(strobe),
    .chEnOut(chEn), .pinOut(pinOut), .irqOut(irqOut)
  );

  tcmp_dp #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .timeVal(timeVal), .wrData(regWdata),
    .strobeIn(strobe), .chEnIn(chEn), .matchOut(match), .activeOut(active)
  );
endmodule

// File: tb/tb_tcmp_top.sv
module tb_tcmp_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] timeVal = '0;
  logic        regWr = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [3:0]  pinOut, irqOut;
  int total = 0;
  int bad = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  tcmp_top dut (.clk(clk), .rstN(rstN), .timeVal(timeVal), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .pinOut(pinOut), .irqOut(irqOut));

  function automatic logic [31:0] ctrlWord(bit f, bit ie, logic [3:0] m);
    return {26'b0, f, ie, m};
  endfunction
  function automatic logic [3:0] ctrlA(int n); return 4'(1 + 2 * n); endfunction
  function automatic logic [3:0] cmpA(int n);  return 4'(2 + 2 * n); endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    regWr = 1'b1; regAddr = a; regWdata = d;
    step();
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdata;
  endtask

  task automatic setTime(input logic [31:0] t);
    timeVal = t; step();
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] c, c2;
    bit ie;
    void'($urandom(32'd4242));
    repeat (3) step();
    rstN = 1'b1;
    step();
    // R1 reset state
    for (int n = 0; n < 4; n++) begin
      rd(ctrlA(n), rv); check("R1 ctrl", rv, 0);
    end
    rd(0, rv); check("R1 status", rv, 0);
    check("R1 pins", {28'b0, pinOut}, 0);
    check("R1 irq", {28'b0, irqOut}, 0);

    // channel 0: toggle, interrupt enabled
    wr(ctrlA(0), 0);
    rd(ctrlA(0), rv); check("R10 mode cleared", rv, 0);
    wr(cmpA(0), 100);
    rd(cmpA(0), rv); check("R10 active loaded", rv, 100);
    wr(ctrlA(0), ctrlWord(0, 1, 4'h5));
    rd(ctrlA(0), rv); check("R12 ctrl layout", rv, ctrlWord(0, 1, 4'h5));
    setTime(99);
    rd(0, rv); check("R2 no early hit", rv, 0);
    setTime(100);
    rd(0, rv); check("R11 status mirror", rv, 1);
    rd(ctrlA(0), rv); check("R2 flag set", rv, ctrlWord(1, 1, 4'h5));
    check("R4 irq high", irqOut[0], 1);
    check("R5 toggle", pinOut[0], 1);
    wr(ctrlA(0), ctrlWord(0, 1, 4'h5));
    rd(0, rv); check("R3 zero keeps flag", rv[0], 1);
    wr(ctrlA(0), ctrlWord(1, 1, 4'h5));
    rd(0, rv); check("R3 flag cleared", rv[0], 0);
    check("R4 irq low", irqOut[0], 0);
    step();
    rd(0, rv); check("R8 disarmed", rv[0], 0);
    check("R5 pin held", pinOut[0], 1);

    // channel 1: pulse with queued value
    setTime(0);
    wr(ctrlA(1), 0);
    wr(cmpA(1), 200);
    wr(ctrlA(1), ctrlWord(0, 0, 4'hF));
    wr(cmpA(1), 300);
    rd(cmpA(1), rv); check("R7 active unchanged", rv, 200);
    setTime(200);
    check("R6 pulse high", pinOut[1], 1);
    rd(0, rv); check("R2 ch1 flag", rv[1], 1);
    check("R4 irq disabled", irqOut[1], 0);
    step();
    check("R6 pulse one cycle", pinOut[1], 0);
    rd(cmpA(1), rv); check("R7 queued now active", rv, 300);
    wr(ctrlA(1), ctrlWord(1, 0, 4'hF));
    setTime(300);
    rd(0, rv); check("R7 second hit", rv[1], 1);
    check("R6 second pulse", pinOut[1], 1);

    // channel 2: disable drops queued value, then other mode code
    setTime(0);
    wr(ctrlA(2), 0);
    wr(cmpA(2), 400);
    wr(ctrlA(2), ctrlWord(0, 0, 4'h5));
    wr(cmpA(2), 500);
    wr(ctrlA(2), 0);
    rd(ctrlA(2), rv); check("R9 mode off", rv, 0);
    wr(ctrlA(2), ctrlWord(0, 0, 4'h5));
    setTime(400);
    rd(0, rv); check("R9 no hit at old", rv[2], 0);
    setTime(500);
    rd(0, rv); check("R9 queued dropped", rv[2], 0);
    check("R9 pin low", pinOut[2], 0);
    wr(ctrlA(2), 0);
    wr(cmpA(2), 600);
    wr(ctrlA(2), ctrlWord(0, 0, 4'h3));
    setTime(600);
    rd(0, rv); check("R2 other code flags", rv[2], 1);
    check("R2 other code pin low", pinOut[2], 0);
    wr(0, 32'hF);
    rd(0, rv); check("R11 status write ignored", rv, 32'h6);

    // channel 3: random double-buffered toggle runs
    for (int k = 0; k < 20; k++) begin
      c  = 32'd1000 + ($urandom % 32'h100000);
      c2 = c + 32'd1 + ($urandom % 32'd1000);
      ie = 1'($urandom % 2);
      setTime(0);
      wr(ctrlA(3), ctrlWord(1, 0, 4'h0));
      wr(cmpA(3), c);
      wr(ctrlA(3), ctrlWord(0, ie, 4'h5));
      wr(cmpA(3), c2);
      setTime(c - 1);
      rd(0, rv); check("R2 rand no early", rv[3], 0);
      setTime(c);
      rd(ctrlA(3), rv); check("R12 rand ctrl", rv, ctrlWord(1, ie, 4'h5));
      check("R5 rand toggle", pinOut[3], 1);
      check("R4 rand irq", irqOut[3], ie);
      wr(ctrlA(3), ctrlWord(1, ie, 4'h5));
      setTime(c2);
      rd(0, rv); check("R7 rand queued hit", rv[3], 1);
      check("R5 rand toggle back", pinOut[3], 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule